// File: doc/BRIEF.md
# Two-Color Hardware Cursor Overlay

This block draws a small cursor over a stream of display pixels. The cursor image sits in a local byte RAM as two 1-bit-per-pixel planes, one directly after the other. For each screen pixel that falls inside the cursor square, the block reads one bit from each plane. The resulting 2-bit code picks one of four outcomes:

- a programmable background color;
- a programmable foreground color;
- the original pixel left unchanged;
- the original pixel with every bit inverted.

Software sets the two colors, the cursor size (32x32 or 64x64), the top-left position and a visible flag through a small register write port. It loads the bitmap through a separate byte write port. The raster side takes pixel coordinates, an RGB value and a valid strobe. It returns the composited RGB with a fixed latency of one clock.

Top module: `cursor_overlay`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is low, the cursor is not visible, the size is 32x32, the position is (0,0) and both colors are zero.
- R2: Inside the cursor square, plane bit pair (first plane, second plane) = 0,0 outputs the background color and 0,1 outputs the foreground color.
- R3: Inside the cursor square, bit pair 1,0 outputs the input pixel unchanged and 1,1 outputs its bitwise inverse.
- R4: Bitmap layout:
  - The first plane starts at byte 0 and the second plane at byte S*S/8, where S is the selected size.
  - Rows are stored top to bottom, each S/8 bytes long.
  - Within a byte, bit 7 is the leftmost pixel.
- R5: A write to the size register is accepted only when `reg_wdata[1:0]` is 2'b01 (32x32) or 2'b10 (64x64). The values 2'b00 and 2'b11 are ignored and the previous size is kept.
- R6: While the visible flag is clear, every output pixel equals its input pixel.
- R7: Only pixels with pos_x <= x < pos_x+S and pos_y <= y < pos_y+S are affected; all others pass through unchanged.
- R8: `out_rgb` and `out_valid` appear exactly one clock after the matching input, and `out_valid` copies `pix_valid`.
- R9: Register map (byte address in `reg_addr`):
  - 0: foreground color, R in [23:16], G in [15:8], B in [7:0].
  - 1: background color, same layout.
  - 2: size.
  - 3: position, x in [15:0] and y in [31:16].
  - 4: visible flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| bm_we | input | 1 | Bitmap byte write strobe |
| bm_addr | input | 10 | Bitmap byte address |
| bm_wdata | input | 8 | Bitmap byte data |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel row |
| pix_rgb | input | 24 | Input pixel color |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Composited pixel color |

## Verification
The hardest situation to reach is the plane offset when the size changes. The second plane moves from byte 128 to byte 512, so a layout error shows only when the full 64x64 image is read after a 32x32 image. The bench loads a distinct arithmetic pattern for each size and sweeps every pixel of each square, plus a three-pixel border, at two different positions. It then issues rejected size writes (both flags clear, both flags set) and probes a pixel that lies inside the large square but outside the small one. That pixel shows whether the size really held.

// File: rtl/cursor_pkg.sv
// Shared constants and types for the cursor overlay.
// Assumes two square sizes that are powers of two and at least 8.
package cursor_pkg;
    localparam int SMALL_DIM = 32;
    localparam int LARGE_DIM = 64;
    localparam int RGB_W     = 24;

    // Register select values
    localparam logic [2:0] RA_FG   = 3'd0;
    localparam logic [2:0] RA_BG   = 3'd1;
    localparam logic [2:0] RA_SIZE = 3'd2;
    localparam logic [2:0] RA_POS  = 3'd3;
    localparam logic [2:0] RA_VIS  = 3'd4;

    typedef enum logic [1:0] {
        PX_BACK  = 2'b00,
        PX_FORE  = 2'b01,
        PX_CLEAR = 2'b10,
        PX_INV   = 2'b11
    } pix_code_e;
endpackage

// File: rtl/cursor_regs.sv
// Cursor control registers: colors, size flags, position, visibility.
// Assumes DATA_W = 2*COORD_W and DATA_W >= 24; size writes with other than
// exactly one flag set are dropped.
module cursor_regs #(
    parameter int COORD_W = 16,
    localparam int DATA_W = 2 * COORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [2:0]         addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [23:0]        fg_rgb,
    output logic [23:0]        bg_rgb,
    output logic               size_large,
    output logic [COORD_W-1:0] pos_x,
    output logic [COORD_W-1:0] pos_y,
    output logic               visible
);
    import cursor_pkg::*;

    logic [1:0] size_flags;
    logic       size_ok;

    // Accept a size value only with exactly one flag set
    always_comb size_ok = (wdata[1:0] == 2'b01) || (wdata[1:0] == 2'b10);

    // Register file update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fg_rgb     <= '0;
            bg_rgb     <= '0;
            size_flags <= 2'b01;
            pos_x      <= '0;
            pos_y      <= '0;
            visible    <= 1'b0;
        end else if (we) begin
            case (addr)
                RA_FG:   fg_rgb <= wdata[23:0];
                RA_BG:   bg_rgb <= wdata[23:0];
                RA_SIZE: if (size_ok) size_flags <= wdata[1:0];
                RA_POS: begin
                    pos_x <= wdata[COORD_W-1:0];
                    pos_y <= wdata[DATA_W-1:COORD_W];
                end
                RA_VIS:  visible <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb size_large = size_flags[1];

    p_size_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(size_flags));
    p_size_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RA_SIZE && wdata[1:0] != 2'b01 && wdata[1:0] != 2'b10)
        |=> $stable(size_flags));
endmodule

// File: rtl/cursor_bitmap_ram.sv
// Byte-wide bitmap storage with one synchronous write port and two
// asynchronous read ports (one per plane). No reset on contents.
module cursor_bitmap_ram #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_a,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem [DEPTH];

    // Byte write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Plane reads
    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end
endmodule

// File: rtl/cursor_hit.sv
// Window test and bitmap addressing for one raster pixel.
// Assumes both sizes are powers of two >= 8 and the RAM holds two large planes.
module cursor_hit #(
    parameter int COORD_W = 16,
    parameter int SMALL   = 32,
    parameter int LARGE   = 64,
    localparam int AW     = $clog2(2 * LARGE * LARGE / 8),
    localparam int SL     = $clog2(SMALL),
    localparam int LL     = $clog2(LARGE)
) (
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic               size_large,
    output logic               hit,
    output logic [AW-1:0]      addr_p0,
    output logic [AW-1:0]      addr_p1,
    output logic [2:0]         bit_idx
);
    localparam logic [AW-1:0] OFS_S = AW'(SMALL * SMALL / 8);
    localparam logic [AW-1:0] OFS_L = AW'(LARGE * LARGE / 8);

    logic [COORD_W:0] dx, dy, dim;
    logic [AW-1:0]    idx_s, idx_l, idx;

    // Offsets from the cursor corner; a borrow into the top bit means "left/above"
    always_comb begin
        dx  = {1'b0, pix_x} - {1'b0, pos_x};
        dy  = {1'b0, pix_y} - {1'b0, pos_y};
        dim = size_large ? (COORD_W+1)'(LARGE) : (COORD_W+1)'(SMALL);
        hit = !dx[COORD_W] && !dy[COORD_W] && (dx < dim) && (dy < dim);
    end

    // Byte index within a plane: row * (size/8) + column/8
    always_comb begin
        idx_s = (AW'(dy[SL-1:0]) << (SL - 3)) + AW'(dx[SL-1:3]);
        idx_l = (AW'(dy[LL-1:0]) << (LL - 3)) + AW'(dx[LL-1:3]);
        idx   = size_large ? idx_l : idx_s;
    end

    // Second plane follows the first; MSB is leftmost pixel
    always_comb begin
        addr_p0 = idx;
        addr_p1 = idx + (size_large ? OFS_L : OFS_S);
        bit_idx = 3'd7 - dx[2:0];
    end
endmodule

// File: rtl/cursor_overlay.sv
// Top: composites a two-color, two-plane cursor onto a pixel stream with a
// one-cycle registered output. Assumes pixels arrive with valid; RAM writes
// and register writes take effect on the following pixel.
module cursor_overlay #(
    parameter int COORD_W = 16,
    localparam int DEPTH  = 2 * cursor_pkg::LARGE_DIM * cursor_pkg::LARGE_DIM / 8,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [2*COORD_W-1:0] reg_wdata,
    input  logic                 bm_we,
    input  logic [AW-1:0]        bm_addr,
    input  logic [7:0]           bm_wdata,
    input  logic                 pix_valid,
    input  logic [COORD_W-1:0]   pix_x,
    input  logic [COORD_W-1:0]   pix_y,
    input  logic [23:0]          pix_rgb,
    output logic                 out_valid,
    output logic [23:0]          out_rgb
);
    import cursor_pkg::*;

    logic [23:0]        fg_rgb, bg_rgb;
    logic               size_large, visible, hit;
    logic [COORD_W-1:0] pos_x, pos_y;
    logic [AW-1:0]      addr_p0, addr_p1;
    logic [7:0]         byte_p0, byte_p1;
    logic [2:0]         bit_idx;
    pix_code_e          code;
    logic [23:0]        mix_rgb;

    cursor_regs #(.COORD_W(COORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .fg_rgb(fg_rgb), .bg_rgb(bg_rgb), .size_large(size_large),
        .pos_x(pos_x), .pos_y(pos_y), .visible(visible)
    );

    cursor_hit #(.COORD_W(COORD_W), .SMALL(SMALL_DIM), .LARGE(LARGE_DIM)) u_hit (
        .pix_x(pix_x), .pix_y(pix_y), .pos_x(pos_x), .pos_y(pos_y),
        .size_large(size_large), .hit(hit), .addr_p0(addr_p0),
        .addr_p1(addr_p1), .bit_idx(bit_idx)
    );

    cursor_bitmap_ram #(.DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(bm_we), .waddr(bm_addr), .wdata(bm_wdata),
        .raddr_a(addr_p0), .raddr_b(addr_p1),
        .rdata_a(byte_p0), .rdata_b(byte_p1)
    );

    // Form the 2-bit code (first plane high) and choose the output color
    always_comb begin
        code = pix_code_e'({byte_p0[bit_idx], byte_p1[bit_idx]});
        if (!visible || !hit) begin
            mix_rgb = pix_rgb;
        end else begin
            case (code)
                PX_BACK:  mix_rgb = bg_rgb;
                PX_FORE:  mix_rgb = fg_rgb;
                PX_CLEAR: mix_rgb = pix_rgb;
                default:  mix_rgb = ~pix_rgb;
            endcase
        end
    end

    // Output register: fixed one-cycle latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= pix_valid;
            out_rgb   <= mix_rgb;
        end
    end

    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    p_idle_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);
    p_hidden_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !visible |=> out_rgb == $past(pix_rgb));
    p_outside_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> out_rgb == $past(pix_rgb));
    p_fore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (visible && hit && code == PX_FORE) |=> out_rgb == $past(fg_rgb));
    p_invert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (visible && hit && code == PX_INV) |=> out_rgb == ~$past(pix_rgb));
endmodule

// File: tb/cursor_overlay_bench.sv
// Self-checking bench: loads arithmetic bitmap patterns and sweeps every
// pixel around the cursor square for both sizes.
module cursor_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        bm_we = 1'b0;
    logic [9:0]  bm_addr = '0;
    logic [7:0]  bm_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic [23:0] pix_rgb = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [23:0] FG = 24'h12A5F0;
    localparam logic [23:0] BG = 24'h0C3366;

    always #10 clk = ~clk;

    cursor_overlay u_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .bm_we(bm_we), .bm_addr(bm_addr),
        .bm_wdata(bm_wdata), .pix_valid(pix_valid), .pix_x(pix_x),
        .pix_y(pix_y), .pix_rgb(pix_rgb), .out_valid(out_valid),
        .out_rgb(out_rgb)
    );

    function automatic bit pat(int sz, int pl, int r, int c);
        return bit'(((r * 7 + c * 3 + pl * 5 + r * c + sz) >> 1) & 1);
    endfunction

    function automatic logic [23:0] in_color(int x, int y);
        return {8'(x), 8'(y), 8'(x ^ (y * 3))};
    endfunction

    task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R9: register write through the port
    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // R4: plane 0 at 0, plane 1 at sz*sz/8, rows of sz/8 bytes, MSB leftmost
    task automatic load_bitmap(int sz);
        int pb = sz * sz / 8;
        for (int pl = 0; pl < 2; pl++) begin
            for (int b = 0; b < pb; b++) begin
                logic [7:0] v;
                int r = b / (sz / 8);
                int c0 = (b % (sz / 8)) * 8;
                for (int k = 0; k < 8; k++) v[7 - k] = pat(sz, pl, r, c0 + k);
                @(negedge clk);
                bm_we = 1'b1; bm_addr = 10'(pl * pb + b); bm_wdata = v;
            end
        end
        @(negedge clk);
        bm_we = 1'b0;
    endtask

    // Present one pixel and check the result one clock later (R8)
    task automatic probe(int x, int y, int sz, int px, int py, bit vis, string force_tag);
        logic [23:0] in = in_color(x, y);
        logic [23:0] exp;
        string tag;
        @(negedge clk);
        pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y); pix_rgb = in;
        if (!vis) begin
            exp = in; tag = "R6";
        end else if (x < px || y < py || x >= px + sz || y >= py + sz) begin
            exp = in; tag = "R7";
        end else begin
            bit p0 = pat(sz, 0, y - py, x - px);
            bit p1 = pat(sz, 1, y - py, x - px);
            case ({p0, p1})
                2'b00: begin exp = BG;  tag = "R2"; end
                2'b01: begin exp = FG;  tag = "R2"; end
                2'b10: begin exp = in;  tag = "R3"; end
                default: begin exp = ~in; tag = "R3"; end
            endcase
        end
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        pix_valid = 1'b0;
        check({tag, " valid"}, {23'd0, out_valid}, 24'd1);
        check(tag, out_rgb, exp);
    endtask

    task automatic sweep(int sz, int px, int py);
        for (int y = py - 3; y < py + sz + 3; y++)
            for (int x = px - 3; x < px + sz + 3; x++)
                probe(x, y, sz, px, py, 1'b1, "");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 valid", {23'd0, out_valid}, 24'd0);
        check("R1 rgb", out_rgb, 24'd0);

        load_bitmap(32);
        // R1/R6: cursor hidden after reset; pixel at the default corner passes
        probe(0, 0, 32, 0, 0, 1'b0, "R1");
        probe(10, 10, 32, 0, 0, 1'b0, "R6");

        // R9: program colors, position, visible; size defaults to 32 (R1)
        wr_reg(3'd0, {8'd0, FG});
        wr_reg(3'd1, {8'd0, BG});
        wr_reg(3'd3, {16'd3, 16'd5});
        wr_reg(3'd4, 32'd1);
        sweep(32, 5, 3);

        // R8: no valid in, no valid out
        @(negedge clk);
        pix_valid = 1'b0;
        @(negedge clk);
        check("R8 idle", {23'd0, out_valid}, 24'd0);

        // Large cursor at a far position
        load_bitmap(64);
        wr_reg(3'd2, 32'h2);
        wr_reg(3'd3, {16'd700, 16'd1000});
        sweep(64, 1000, 700);

        // R5: rejected size values keep 64x64
        wr_reg(3'd2, 32'h0);
        probe(1040, 740, 64, 1000, 700, 1'b1, "R5");
        wr_reg(3'd2, 32'h3);
        probe(1040, 740, 64, 1000, 700, 1'b1, "R5");
        probe(1063, 763, 64, 1000, 700, 1'b1, "R5");

        // R5: valid switch to 32 makes the same pixel fall outside
        wr_reg(3'd2, 32'h1);
        probe(1040, 740, 32, 1000, 700, 1'b1, "R5");

        // R6: hide the cursor; in-window pixels pass
        wr_reg(3'd4, 32'd0);
        for (int i = 0; i < 8; i++) probe(1000 + i * 3, 700 + i, 32, 1000, 700, 1'b0, "R6");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule